// File: doc/BRIEF.md
# Flash Program/Erase Suspend Controller

This block is the part of a NOR flash command interface that pauses and restarts the internal write engine. A host issues single-cycle bus writes carrying an 8-bit opcode. Program, buffered program and erase opcodes start a write operation. While that operation runs, a suspend opcode asks the engine to pause. After a fixed latency the engine stops and a status bit reports the pause. A resume opcode restarts it. Two cycle counters, one for programming and one for erasing, stand in for the real engine. The block exposes their start, pause and done signals so that they can be observed.

While an erase is paused, the host may start a program and may also pause that program. Resume always restarts the innermost paused operation. After a program has run inside an erase pause, a read-array opcode must come before the erase is allowed to resume. The status port reports three things: controller activity on bit 7, a paused erase on bit 6 and a paused program on bit 2. A read-mode output shows what ordinary reads would return. Every write that the block accepts is acknowledged by a one-cycle pulse. A rejected write changes nothing.

Top module: `flash_susp_ctrl`

## Requirements
- R1: After reset, status is 80h (bit 7 = 1, all other bits 0), rd_mode is 0 (array) and no engine channel is busy.
- R2: When idle with nothing paused, program 40h, buffered program E8h and erase 20h are accepted. Each starts an engine channel (index 0 program, index 1 erase) and sets rd_mode to 1 (status). Status bit 7 reads 0 from the cycle after the write until the channel has counted its full length, then reads 1.
- R3: While an operation is running and no pause is pending, only suspend (B0h) is accepted. Every other opcode, including unknown ones, is rejected.
- R4: An accepted suspend pauses the running operation and sets status bit 7 exactly SUSP_LAT cycles after the write edge. The same update sets bit 2 if a program was running, or bit 6 if an erase was running.
- R5: Between an accepted suspend and the pause, every write is rejected and status bit 7 stays 0.
- R6: If the running operation completes inside the suspend latency window, the pending request is dropped. Status returns to 80h with bits 2 and 6 at 0.
- R7: A suspend is ignored (no acknowledge) when nothing is running or when the only operations present are already paused. A resume with nothing paused is also rejected.
- R8: During any pause, read array FFh, read status 70h, read signature 90h and read query 98h are accepted. They set rd_mode to 0 (array), 1 (status), 2 (signature) or 3 (query).
- R9: During a program pause, program, buffered program, erase and protection configuration (60h) are rejected.
- R10: During an erase pause, program, buffered program and protection configuration are accepted and erase is rejected. A suspend of the nested program is accepted and yields status C4h.
- R11: Resume (D0h) restarts the innermost paused operation, clearing bit 2 if a program is paused and otherwise bit 6. Bit 7 then reads 0 while that operation runs.
- R12: After a program is started inside an erase pause, resume is rejected until a read-array opcode is accepted.
- R13: cmd_ok is a one-cycle pulse in the cycle after an accepted write and stays 0 after a rejected write. A rejected write leaves rd_mode and status bits 6 and 2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per command |
| wr_cmd | input | 8 | Command opcode |
| status | output | 8 | Status: bit 7 ready, bit 6 erase paused, bit 2 program paused |
| rd_mode | output | 2 | Read output select: 0 array, 1 status, 2 signature, 3 query |
| cmd_ok | output | 1 | Acknowledge pulse for an accepted write |
| eng_start | output | 2 | Channel start pulses (0 program, 1 erase) |
| eng_pause | output | 2 | Channel pause levels |
| eng_done | output | 2 | Channel completion pulses |

## Verification
Opcode sequences are applied in every controller situation: idle, running, suspend pending, program paused, erase paused, and a program nested inside an erase pause. The same opcode is therefore seen both accepted and rejected, which separates the legality rules of each situation. Suspends are timed early in an operation to measure the exact pause latency. A suspend is also placed two cycles before completion, which tells a finished operation apart from a paused one. Resume ordering is checked on the nested case, before and after the mandatory read-array.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_SIG    = 2'd2,
        RD_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_RD_ARRAY,
        K_RD_STAT,
        K_RD_SIG,
        K_RD_QUERY,
        K_PROG,
        K_ERASE,
        K_PROT,
        K_SUSP,
        K_RES
    } cmd_kind_e;

    localparam int NUM_CH = 2;
    localparam int CH_PROG = 0;
    localparam int CH_ERASE = 1;

endpackage

// File: rtl/fsc_decode.sv
module fsc_decode
    import fsc_pkg::*;
#(
    parameter logic [7:0] OP_SUSP     = 8'hB0,
    parameter logic [7:0] OP_RES      = 8'hD0,
    parameter logic [7:0] OP_RD_ARRAY = 8'hFF,
    parameter logic [7:0] OP_RD_STAT  = 8'h70,
    parameter logic [7:0] OP_RD_SIG   = 8'h90,
    parameter logic [7:0] OP_RD_QUERY = 8'h98,
    parameter logic [7:0] OP_PROG     = 8'h40,
    parameter logic [7:0] OP_BUFPROG  = 8'hE8,
    parameter logic [7:0] OP_ERASE    = 8'h20,
    parameter logic [7:0] OP_PROT     = 8'h60
) (
    input  logic [7:0] opcode,
    output cmd_kind_e  kind
);
    always_comb begin
        kind = K_NONE;
        if      (opcode == OP_SUSP)     kind = K_SUSP;
        else if (opcode == OP_RES)      kind = K_RES;
        else if (opcode == OP_RD_ARRAY) kind = K_RD_ARRAY;
        else if (opcode == OP_RD_STAT)  kind = K_RD_STAT;
        else if (opcode == OP_RD_SIG)   kind = K_RD_SIG;
        else if (opcode == OP_RD_QUERY) kind = K_RD_QUERY;
        else if (opcode == OP_PROG)     kind = K_PROG;
        else if (opcode == OP_BUFPROG)  kind = K_PROG;
        else if (opcode == OP_ERASE)    kind = K_ERASE;
        else if (opcode == OP_PROT)     kind = K_PROT;
    end
endmodule

// File: rtl/fsc_gate.sv
module fsc_gate
    import fsc_pkg::*;
(
    input  cmd_kind_e kind,
    input  logic      fg_busy,
    input  logic      pend,
    input  logic      pg_susp,
    input  logic      er_susp,
    input  logic      need_rd,
    output logic      legal
);
    logic is_read;

    always_comb begin
        is_read = (kind == K_RD_ARRAY) || (kind == K_RD_STAT) ||
                  (kind == K_RD_SIG)   || (kind == K_RD_QUERY);
        if (fg_busy || pend) begin
            legal = (kind == K_SUSP) && fg_busy && !pend;
        end else if (pg_susp) begin
            legal = is_read || (kind == K_RES);
        end else if (er_susp) begin
            legal = is_read || (kind == K_PROG) || (kind == K_PROT) ||
                    ((kind == K_RES) && !need_rd);
        end else begin
            legal = is_read || (kind == K_PROG) || (kind == K_ERASE) ||
                    (kind == K_PROT);
        end
    end
endmodule

// File: rtl/fsc_engine.sv
module fsc_engine #(
    parameter int LEN = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pause,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_C = CW'(LEN);

    logic [CW-1:0] rem_d, rem_q;
    logic          done_d, done_q;

    always_comb begin
        rem_d  = rem_q;
        done_d = 1'b0;
        if (start) begin
            rem_d = LEN_C;
        end else if (rem_q != '0 && !pause) begin
            rem_d  = rem_q - 1'b1;
            done_d = (rem_q == CW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            done_q <= 1'b0;
        end else begin
            rem_q  <= rem_d;
            done_q <= done_d;
        end
    end

    assign busy = (rem_q != '0);
    assign done = done_q;

    // R4
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !start) |=> (rem_q == $past(rem_q)));
endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl
    import fsc_pkg::*;
#(
    parameter int         PROG_CYCLES  = 20,
    parameter int         ERASE_CYCLES = 40,
    parameter int         SUSP_LAT     = 4,
    parameter logic [7:0] OP_SUSP      = 8'hB0,
    parameter logic [7:0] OP_RES       = 8'hD0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_cmd,
    output logic [7:0] status,
    output logic [1:0] rd_mode,
    output logic       cmd_ok,
    output logic [1:0] eng_start,
    output logic [1:0] eng_pause,
    output logic [1:0] eng_done
);
    localparam int LW = (SUSP_LAT > 1) ? $clog2(SUSP_LAT) : 1;
    localparam logic [LW-1:0] LAT_LOAD = LW'(SUSP_LAT - 1);

    typedef struct packed {
        logic          pend;
        logic [LW-1:0] lat;
        logic          pg_susp;
        logic          er_susp;
        logic          need_rd;
        logic          ok;
        rd_mode_e      mode;
    } ctl_t;

    ctl_t       d, q;
    cmd_kind_e  kind;
    logic       legal;
    logic [1:0] ch_busy;
    logic [1:0] start;
    logic       pg_run, er_run, fg_any;

    fsc_decode #(.OP_SUSP(OP_SUSP), .OP_RES(OP_RES)) u_dec (
        .opcode(wr_cmd),
        .kind  (kind)
    );

    assign pg_run = ch_busy[CH_PROG]  && !q.pg_susp;
    assign er_run = ch_busy[CH_ERASE] && !q.er_susp;
    assign fg_any = pg_run || er_run;

    fsc_gate u_gate (
        .kind   (kind),
        .fg_busy(fg_any),
        .pend   (q.pend),
        .pg_susp(q.pg_susp),
        .er_susp(q.er_susp),
        .need_rd(q.need_rd),
        .legal  (legal)
    );

    assign eng_pause = {q.er_susp, q.pg_susp};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fsc_engine #(.LEN((c == CH_PROG) ? PROG_CYCLES : ERASE_CYCLES)) u_eng (
            .clk  (clk),
            .rst_n(rst_n),
            .start(start[c]),
            .pause(eng_pause[c]),
            .busy (ch_busy[c]),
            .done (eng_done[c])
        );
    end

    always_comb begin
        d     = q;
        d.ok  = 1'b0;
        start = '0;
        if (q.pend) begin
            if (!fg_any) begin
                d.pend = 1'b0;
            end else if (q.lat == '0) begin
                d.pend = 1'b0;
                if (pg_run) d.pg_susp = 1'b1;
                else        d.er_susp = 1'b1;
            end else begin
                d.lat = q.lat - 1'b1;
            end
        end
        if (wr_en && legal) begin
            d.ok = 1'b1;
            case (kind)
                K_RD_ARRAY: begin
                    d.mode    = RD_ARRAY;
                    d.need_rd = 1'b0;
                end
                K_RD_STAT:  d.mode = RD_STATUS;
                K_RD_SIG:   d.mode = RD_SIG;
                K_RD_QUERY: d.mode = RD_QUERY;
                K_PROG: begin
                    start[CH_PROG] = 1'b1;
                    d.mode = RD_STATUS;
                    if (q.er_susp) d.need_rd = 1'b1;
                end
                K_ERASE: begin
                    start[CH_ERASE] = 1'b1;
                    d.mode = RD_STATUS;
                end
                K_PROT: d.mode = RD_STATUS;
                K_SUSP: begin
                    d.pend = 1'b1;
                    d.lat  = LAT_LOAD;
                    d.mode = RD_STATUS;
                end
                K_RES: begin
                    if (q.pg_susp) d.pg_susp = 1'b0;
                    else           d.er_susp = 1'b0;
                    d.mode = RD_STATUS;
                end
                default: d.ok = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{pend: 1'b0, lat: '0, pg_susp: 1'b0, er_susp: 1'b0,
                   need_rd: 1'b0, ok: 1'b0, mode: RD_ARRAY};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status    = '0;
        status[7] = !(fg_any || q.pend);
        status[6] = q.er_susp;
        status[2] = q.pg_susp;
    end

    assign rd_mode   = q.mode;
    assign cmd_ok    = q.ok;
    assign eng_start = start;

    // R5
    pend_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && q.pend) |=> !cmd_ok);

    // R7
    idle_susp_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_SUSP && !fg_any) |=> !cmd_ok);

    // R12
    resume_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == K_RES && q.need_rd && !q.pg_susp) |=> !cmd_ok);

    // R13
    reject_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !legal) |=> (rd_mode == $past(rd_mode)));

    // R10
    one_fg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pg_run, er_run}));

    // R4
    susp_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> $past(q.pend));
endmodule

// File: tb/flash_susp_ctrl_tb.sv
module flash_susp_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_cmd = 8'h00;
    logic [7:0] status;
    logic [1:0] rd_mode;
    logic       cmd_ok;
    logic [1:0] eng_start, eng_pause, eng_done;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    flash_susp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .status(status), .rd_mode(rd_mode), .cmd_ok(cmd_ok),
        .eng_start(eng_start), .eng_pause(eng_pause), .eng_done(eng_done)
    );

    // {opcode, wait cycles, expected status, {3'b0, ok, 2'b0, mode}}
    localparam int N = 32;
    localparam logic [31:0] VEC [N] = '{
        32'h70_00_80_11, // R8 R13 read status idle
        32'h90_00_80_12, // R8 signature
        32'h98_00_80_13, // R8 query
        32'hFF_00_80_10, // R8 array
        32'h60_00_80_11, // R2 protection idle
        32'hD0_00_80_01, // R7 resume idle
        32'hB0_00_80_01, // R7 suspend idle
        32'h40_01_00_11, // R2 program
        32'hFF_00_00_01, // R3 reject while running
        32'hB0_02_00_11, // R4 R5 suspend pending
        32'hFF_01_84_01, // R5 R4 reject, then paused
        32'hB0_00_84_01, // R7 already paused
        32'h40_00_84_01, // R9
        32'h60_00_84_01, // R9
        32'h20_00_84_01, // R9
        32'hFF_00_84_10, // R8
        32'hD0_01_00_11, // R11
        32'h00_0E_80_01, // R2 R3 completion
        32'h20_01_00_11, // R2 erase
        32'hB0_04_C0_11, // R4 erase paused
        32'h20_00_C0_01, // R10 erase rejected
        32'hB0_00_C0_01, // R7
        32'h60_00_C0_11, // R10 protection
        32'h40_01_40_11, // R10 nested program
        32'hB0_04_C4_11, // R10 nested suspend
        32'hD0_19_C0_11, // R11 program resumes first
        32'hD0_00_C0_01, // R12 needs read array
        32'hFF_00_C0_10, // R12
        32'hD0_01_00_11, // R11 erase resumes
        32'h00_2A_80_01, // R2 erase done
        32'hE8_01_00_11, // R2 buffered program
        32'h00_16_80_01  // R2 done
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] op);
        @(negedge clk);
        wr_en = 1'b1;
        wr_cmd = op;
        @(negedge clk);
        wr_en = 1'b0;
        wr_cmd = 8'h00;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 status", status, 8'h80);
        check("R1 rd_mode", {6'b0, rd_mode}, 8'h00);
        check("R1 engines", {6'b0, eng_pause}, 8'h00);

        for (int i = 0; i < N; i++) begin
            wr(VEC[i][31:24]);
            check($sformatf("R13 ok row %0d", i), {7'b0, cmd_ok}, {7'b0, VEC[i][4]});
            repeat (int'(VEC[i][23:16])) @(negedge clk);
            check($sformatf("R11 status row %0d", i), status, VEC[i][15:8]);
            check($sformatf("R8 mode row %0d", i), {6'b0, rd_mode}, {6'b0, VEC[i][1:0]});
        end

        // R13 acknowledge lasts one cycle
        wr(8'h70);
        check("R13 pulse high", {7'b0, cmd_ok}, 8'h01);
        @(negedge clk);
        check("R13 pulse low", {7'b0, cmd_ok}, 8'h00);

        // R6 completion inside the suspend window
        wr(8'h40);
        repeat (17) @(negedge clk);
        wr(8'hB0);
        check("R6 suspend ack", {7'b0, cmd_ok}, 8'h01);
        @(negedge clk);
        check("R5 busy in window", status, 8'h00);
        repeat (3) @(negedge clk);
        check("R6 finished not paused", status, 8'h80);
        repeat (4) @(negedge clk);
        check("R6 stays finished", status, 8'h80);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule